// File: doc/BRIEF.md
# Single-Wire Bus Reset and Command Controller

This block holds the command register of a single-wire bus master and runs the bus reset sequence. A CPU writes the register through a small port (3-bit address, write strobe, write data) and reads it back through a registered read-data bus. Writing the reset bit pulls the open-drain line low for a set time. The block then releases the line and samples it once for a slave presence pulse. When the recovery time has elapsed, it raises a completion flag and a result flag.

The same register also holds a force-low bit and the search-accelerator mode bit. The force-low bit pulls the line low only while an enable from another register is high. The mode bit is cleared whenever a reset starts. The bus input passes through a two-flop synchroniser. Its synchronised value is shown as a read-only register bit and is also the value the presence sampler uses. All timing is counted in ticks of a prescaled clock, so each phase length is a parameter.

Top module: `swb_cmd_ctrl`

## Requirements
- R1: The command register is at address 000b. Its read value is {4'b0000, line, force_low, search_mode, reset_busy}, with bit 3 = line, bit 2 = force_low, bit 1 = search_mode and bit 0 = reset_busy. Reads from any other address return 8'h00. Read data appears one clock after the address is presented.
- R2: Bit 3 follows the bus input through a two-flop synchroniser. A change on the input is visible in the read data within 4 clocks.
- R3: While `force_en` is 1, setting the force-low bit (bit 2) drives `bus_oe` to 1. While `force_en` is 0, the force-low bit has no effect on `bus_oe`.
- R4: Writing bit 1 sets or clears search mode. A write with bit 0 = 1 starts a reset and clears search mode in the same write, whatever bit 1 holds.
- R5: A started reset holds `bus_oe` at 1 for exactly LOW_TICKS*CLKS_PER_TICK clocks.
- R6: The reset bit (bit 0) reads 1 while a sequence is running. It clears itself when the sequence ends and reads 0 whenever no sequence runs.
- R7: `presence_irq` rises exactly REL_TICKS*CLKS_PER_TICK clocks after the last clock in which `bus_oe` was 1 for the reset. It is cleared when a new reset starts.
- R8: The synchronised line is sampled once, on the SAMPLE_TICKS-th tick after release. `presence_none` is 0 if the sample was low (slave present) and 1 if it was high.
- R9: The synchronous reset `rst` clears all register bits, the flags, the read data and `bus_oe`.
- R10: Writes to addresses other than 000b change nothing in the command register.
- R11: A reset write made while a sequence runs is ignored. The running sequence is not restarted or lengthened.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 3 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| force_en | input | 1 | Enable for the force-low bit, from another register |
| bus_in | input | 1 | Sampled bus line level |
| bus_oe | output | 1 | 1 pulls the open-drain line low |
| presence_irq | output | 1 | Reset sequence completed |
| presence_none | output | 1 | 1 = no presence pulse seen, 0 = slave answered |

## Verification
The reset sequence is exercised with slave responses placed at several positions relative to the sampling tick: a long pulse, a pulse that just covers the sample, one that ends too early, one that starts too late, and no pulse at all. This separates a correct single-point sample from a sampler that uses the wrong tick, wrong polarity or a missing synchroniser stage. Each run also measures the drive length and the completion delay in clocks, and so catches off-by-one errors in the phase counters. Further tests cover the force-enable gating, the mode bit cleared by a reset write, writes to other addresses, and a repeated reset write during a running sequence.

// File: rtl/swb_pkg.sv
package swb_pkg;
  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_LOW  = 2'd1,
    SQ_WAIT = 2'd2,
    SQ_REC  = 2'd3
  } sq_state_t;

  localparam logic [2:0] CMD_ADDR = 3'b000;
  localparam int BIT_RST   = 0;
  localparam int BIT_SRCH  = 1;
  localparam int BIT_FORCE = 2;
  localparam int BIT_LINE  = 3;
endpackage

// File: rtl/swb_sync.sv
module swb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '1;
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/swb_tick.sv
module swb_tick #(
  parameter int DIV = 100
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  generate
    if (DIV <= 1) begin : g_direct
      assign tick = run;
    end else begin : g_div
      localparam int PW = $clog2(DIV);
      logic [PW-1:0] pcnt;
      always_ff @(posedge clk) begin
        if (rst || !run)                  pcnt <= '0;
        else if (pcnt == PW'(DIV - 1))    pcnt <= '0;
        else                              pcnt <= pcnt + 1'b1;
      end
      assign tick = run && (pcnt == PW'(DIV - 1));
    end
  endgenerate
endmodule

// File: rtl/swb_rst_seq.sv
module swb_rst_seq
  import swb_pkg::*;
#(
  parameter int LOW_TICKS    = 480,
  parameter int SAMPLE_TICKS = 70,
  parameter int REL_TICKS    = 480
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic tick,
  input  logic line,
  output logic busy,
  output logic drive_low,
  output logic done_flag,
  output logic none_flag
);
  localparam int MAXT = (LOW_TICKS > REL_TICKS) ? LOW_TICKS : REL_TICKS;
  localparam int CW   = $clog2(MAXT + 1);

  sq_state_t     state;
  logic [CW-1:0] cnt;
  logic          seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= SQ_IDLE;
      cnt       <= '0;
      seen      <= 1'b0;
      done_flag <= 1'b0;
      none_flag <= 1'b0;
    end else begin
      case (state)
        SQ_IDLE: if (start) begin
          state     <= SQ_LOW;
          cnt       <= '0;
          done_flag <= 1'b0;
        end
        SQ_LOW: if (tick) begin
          if (cnt == CW'(LOW_TICKS - 1)) begin
            state <= SQ_WAIT;
            cnt   <= '0;
          end else cnt <= cnt + 1'b1;
        end
        SQ_WAIT: if (tick) begin
          cnt <= cnt + 1'b1;
          if (cnt == CW'(SAMPLE_TICKS - 1)) begin
            seen  <= ~line;
            state <= SQ_REC;
          end
        end
        SQ_REC: if (tick) begin
          if (cnt == CW'(REL_TICKS - 1)) begin
            state     <= SQ_IDLE;
            cnt       <= '0;
            done_flag <= 1'b1;
            none_flag <= ~seen;
          end else cnt <= cnt + 1'b1;
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end

  assign busy      = (state != SQ_IDLE);
  assign drive_low = (state == SQ_LOW);
endmodule

// File: rtl/swb_cmd_ctrl.sv
module swb_cmd_ctrl
  import swb_pkg::*;
#(
  parameter int CLKS_PER_TICK = 100,
  parameter int LOW_TICKS     = 480,
  parameter int SAMPLE_TICKS  = 70,
  parameter int REL_TICKS     = 480,
  parameter int SYNC_STAGES   = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] reg_addr,
  input  logic       reg_wr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       force_en,
  input  logic       bus_in,
  output logic       bus_oe,
  output logic       presence_irq,
  output logic       presence_none
);
  logic line_sync, tick, seq_busy, seq_drive;
  logic fow_q, sra_q, oe_q;
  logic [7:0] rdata_q;
  logic cmd_wr, seq_start;

  assign cmd_wr    = reg_wr && (reg_addr == CMD_ADDR);
  assign seq_start = cmd_wr && reg_wdata[BIT_RST] && !seq_busy;

  swb_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst(rst), .d(bus_in), .q(line_sync)
  );

  swb_tick #(.DIV(CLKS_PER_TICK)) tick_i (
    .clk(clk), .rst(rst), .run(seq_busy), .tick(tick)
  );

  swb_rst_seq #(
    .LOW_TICKS(LOW_TICKS), .SAMPLE_TICKS(SAMPLE_TICKS), .REL_TICKS(REL_TICKS)
  ) seq_i (
    .clk(clk), .rst(rst), .start(seq_start), .tick(tick), .line(line_sync),
    .busy(seq_busy), .drive_low(seq_drive),
    .done_flag(presence_irq), .none_flag(presence_none)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      fow_q   <= 1'b0;
      sra_q   <= 1'b0;
      oe_q    <= 1'b0;
      rdata_q <= '0;
    end else begin
      if (cmd_wr) begin
        fow_q <= reg_wdata[BIT_FORCE];
        sra_q <= reg_wdata[BIT_SRCH] & ~reg_wdata[BIT_RST];
      end
      oe_q <= seq_drive | (fow_q & force_en);
      if (reg_addr == CMD_ADDR)
        rdata_q <= {4'b0000, line_sync, fow_q, sra_q, seq_busy};
      else
        rdata_q <= '0;
    end
  end

  assign reg_rdata = rdata_q;
  assign bus_oe    = oe_q;
endmodule

// File: rtl/swb_cmd_ctrl_chk.sv
module swb_cmd_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic [2:0] reg_addr,
  input logic       reg_wr,
  input logic [7:0] reg_wdata,
  input logic [7:0] reg_rdata,
  input logic       force_en,
  input logic       bus_oe,
  input logic       presence_irq,
  input logic       busy,
  input logic       sra
);
  assert_rsvd_zero_R1: assert property (@(posedge clk) disable iff (rst)
    reg_rdata[7:4] == 4'b0000);

  assert_force_gate_R3: assert property (@(posedge clk) disable iff (rst)
    (!force_en && !busy) |=> !bus_oe);

  assert_mode_cleared_R4: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == 3'b000 && reg_wdata[0]) |=> !sra);

  assert_drive_start_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |=> bus_oe);

  assert_done_flag_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> presence_irq);

  assert_flag_clear_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> !presence_irq);

  assert_reset_state_R9: assert property (@(posedge clk)
    rst |=> (!bus_oe && reg_rdata == 8'h00 && !presence_irq));
endmodule

bind swb_cmd_ctrl swb_cmd_ctrl_chk chk_i (
  .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .force_en(force_en),
  .bus_oe(bus_oe), .presence_irq(presence_irq),
  .busy(seq_busy), .sra(sra_q)
);

// File: tb/swb_cmd_ctrl_tb_top.sv
module swb_cmd_ctrl_tb_top;
  localparam int DIV  = 2;
  localparam int LOWT = 20;
  localparam int SMPT = 7;
  localparam int RELT = 20;
  localparam int NVEC = 5;

  typedef struct packed {
    logic [7:0] p_start;
    logic [7:0] p_end;
    logic       exp_none;
  } vec_t;

  // slave pulse window in clocks after release; sample falls near clock 14
  localparam vec_t VECS [NVEC] = '{
    '{8'd3,  8'd30, 1'b0},
    '{8'd9,  8'd20, 1'b0},
    '{8'd0,  8'd0,  1'b1},
    '{8'd2,  8'd8,  1'b1},
    '{8'd13, 8'd25, 1'b1}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [2:0] reg_addr = '0;
  logic reg_wr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic force_en = 1'b0;
  logic slave_low = 1'b0;
  logic ext_low = 1'b0;
  logic bus_in, bus_oe, presence_irq, presence_none;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always #5 clk = ~clk;
  assign bus_in = ~(bus_oe | slave_low | ext_low);

  swb_cmd_ctrl #(
    .CLKS_PER_TICK(DIV), .LOW_TICKS(LOWT), .SAMPLE_TICKS(SMPT), .REL_TICKS(RELT)
  ) dut_i (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .force_en(force_en),
    .bus_in(bus_in), .bus_oe(bus_oe), .presence_irq(presence_irq),
    .presence_none(presence_none)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    repeat (2) @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic run_reset(input logic [7:0] ps, input logic [7:0] pe,
                           input logic exp_none, input bit rewrite);
    int hi, k;
    logic [7:0] rv;
    hi = 0;
    @(negedge clk);
    reg_addr = 3'b000; reg_wdata = 8'h03; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
    k = 0;
    while (!(hi > 0 && !bus_oe) && k < 1000) begin
      @(negedge clk);
      k++;
      if (bus_oe) hi++;
      if (k == 4) begin
        check("R6 busy bit during reset", reg_rdata[0], 1);
        check("R4 mode cleared by reset write", reg_rdata[1], 0);
        check("R7 flag cleared at start", presence_irq, 0);
      end
      if (rewrite && k == 10) reg_wr = 1'b1;   // R11 repeat reset write
      if (rewrite && k == 11) reg_wr = 1'b0;
    end
    check("R5 drive length", hi, LOWT * DIV);
    k = 0;
    while (!presence_irq && k < 1000) begin
      if (k == int'(ps) && pe != 0) slave_low = 1'b1;
      if (k == int'(pe)) slave_low = 1'b0;
      @(negedge clk);
      k++;
    end
    slave_low = 1'b0;
    check("R7 completion delay", k, RELT * DIV - 1);
    check("R8 presence result", presence_none, exp_none);
    rd(3'b000, rv);
    check("R6 busy bit self-clears", rv[0], 0);
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] rv;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R9 reset state
    check("R9 rdata after reset", reg_rdata, 0);
    check("R9 bus_oe after reset", bus_oe, 0);
    check("R9 flag after reset", presence_irq, 0);
    // R1 layout, R2 live line
    rd(3'b000, rv);
    check("R1 idle read", rv, 8'h08);
    ext_low = 1'b1;
    repeat (4) @(negedge clk);
    check("R2 line low visible", reg_rdata[3], 0);
    ext_low = 1'b0;
    repeat (4) @(negedge clk);
    check("R2 line high visible", reg_rdata[3], 1);
    // R3 force gating
    force_en = 1'b0;
    wr(3'b000, 8'h04);
    repeat (3) @(negedge clk);
    check("R3 force ignored without enable", bus_oe, 0);
    check("R1 force bit read back", reg_rdata, 8'h0C);
    force_en = 1'b1;
    repeat (2) @(negedge clk);
    check("R3 force drives with enable", bus_oe, 1);
    wr(3'b000, 8'h00);
    repeat (2) @(negedge clk);
    check("R3 force released", bus_oe, 0);
    force_en = 1'b0;
    // R4 search mode set
    wr(3'b000, 8'h02);
    rd(3'b000, rv);
    check("R4 mode set", rv, 8'h0A);
    // R10 writes elsewhere
    wr(3'b011, 8'hFF);
    rd(3'b000, rv);
    check("R10 other address write ignored", rv, 8'h0A);
    rd(3'b011, rv);
    check("R1 other address reads zero", rv, 0);
    // R5..R8 table of presence patterns
    for (int i = 0; i < NVEC; i++)
      run_reset(VECS[i].p_start, VECS[i].p_end, VECS[i].exp_none, 1'b0);
    // R11 reset write while running
    run_reset(8'd3, 8'd30, 1'b0, 1'b1);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule